// File: doc/BRIEF.md
# MDIO Command Gateway Master

This block is a management-bus master for Clause 22 PHY access. Software sees two 32-bit words on a small memory-mapped write/read port: a gateway word that carries a complete command and later its result, and a configuration word that sets MDC timing and pad controls. Software writes a command into the gateway word with the busy bit set. The block then shifts the full management frame out on MDC and MDIO and clears busy once the last bit period has ended. For a read, the 16 bits returned by the PHY are left in the low half of the gateway word.

MDC is derived from the core clock through a single phase counter. One MDC period spans 2*(N+1) core clocks, with N taken from the configuration word. MDC is low for the first N+1 clocks and high for the rest. Inside each period, one programmable phase offset sets when the block updates its MDIO output and another sets when it samples MDIO input. A tri-state pad cell, selectable between push-pull and open-drain at elaboration, connects to the bidirectional MDIO pin. Writing an all-zero gateway word aborts any transfer in progress.

Top module: `mdio_gw_master`

## Requirements
- R1: After reset the gateway word reads 0x00000000 and the configuration word reads 0x0D065515. MDC is low, the MDIO output enable is off, and the pad outputs show mode 1, 3.3 V select 1 and full drive 1.
- R2: A gateway write (byte offset 0x0) with bit 30 set while idle starts a frame. Bit 30 (busy) reads 1 from the next cycle for exactly 128*(N+1) core clocks and then reads 0.
- R3: During a frame, MDC is low for the first N+1 core clocks of each 2*(N+1)-clock period and high for the remaining N+1. N is configuration bits 15:8.
- R4: The frame, sampled by the PHY on MDC rising edges, is 32 ones, then 0, then gateway bit 28, then opcode bits 27:26, the PHY address in bits 25:21 and the register address in bits 20:16, each sent MSB first.
- R5: For opcode 1 (write), the block drives turnaround bits 1 then 0 and then gateway bits 15:0, MSB first. The output enable stays on from its first assertion to the end of the frame. Afterwards the gateway word reads the command with bit 30 cleared.
- R6: For opcode 2 (read), the output enable is off from the first turnaround bit period to the end of the frame. Afterwards the gateway word holds bits 28:16 of the command, busy 0, and the captured PHY data in bits 15:0.
- R7: The MDIO output and its enable change only in the clock after the phase counter equals configuration bits 31:24. The first enable assertion in a frame appears at core clock offset+1 of the frame.
- R8: Each read data bit is the MDIO level in the core clock where the phase counter equals configuration bits 23:16 within that bit's period.
- R9: A non-zero gateway write while busy is 1 is ignored. The running frame and the stored command fields are unchanged.
- R10: An all-zero gateway write aborts at once. In the next cycle busy reads 0, the gateway word reads 0, MDC is low and the output enable is off.
- R11: The configuration word (byte offset 0x4) reads back the full 32 bits written. Bits 1:0 drive the pad mode output, bit 2 the 3.3 V select and bit 4 the full-drive enable.
- R12: Whenever busy is 0, MDC is low and the MDIO output enable is off.
- R13: A gateway write with bit 30 clear while idle stores the word without starting a frame. Bits 31 and 29 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address; 0x0 gateway, 0x4 configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio | inout | 1 | Bidirectional management data pin |
| mdio_drive_en | output | 1 | MDIO output enable as seen by the pad |
| pad_mode | output | 2 | Pad mode control from configuration |
| pad_3v3 | output | 1 | Pad 3.3 V select from configuration |
| pad_full_drive | output | 1 | Pad full-drive enable from configuration |

## Verification
A phase counter that wraps at the wrong count shows at the pins within the first MDC period, as an MDC high time or period different from N+1 and 2*(N+1) clocks. A bit index that slips either misplaces a field in what the PHY decodes or shifts busy release away from 128*(N+1) clocks, so the fault is visible by the end of the frame. A bad sample point or capture register shows as wrong low-half data in the gateway word as soon as busy falls. A mishandled abort or intruding write shows in the next cycle's gateway readback, MDC level or output enable.

// File: rtl/mdio_gw_pkg.sv
package mdio_gw_pkg;

   localparam int FLD_W      = 8;
   localparam int GW_BUSY    = 30;
   localparam int GW_ST      = 28;
   localparam int GW_OP_LSB  = 26;
   localparam int GW_PHY_LSB = 21;
   localparam int GW_REG_LSB = 16;

   localparam logic [1:0]  OP_WRITE = 2'b01;
   localparam logic [1:0]  OP_READ  = 2'b10;
   localparam logic [31:0] GW_KEEP  = 32'h5FFF_FFFF;

   typedef struct packed {
      logic [FLD_W-1:0] out_off;
      logic [FLD_W-1:0] in_off;
      logic [FLD_W-1:0] half_n;
      logic [2:0]       spare_hi;
      logic             full_drv;
      logic             spare_lo;
      logic             sel_3v3;
      logic [1:0]       mode;
   } mdio_cfg_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int FLD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [FLD_W-1:0] half_n,
   input  logic [FLD_W-1:0] in_off,
   input  logic [FLD_W-1:0] out_off,
   output logic             mdc,
   output logic             out_stb,
   output logic             in_stb,
   output logic             wrap_stb
);
   localparam int CNT_W = FLD_W + 1;

   logic [CNT_W-1:0] phase, phase_nx, phase_last;
   logic             active;

   assign phase_last = {half_n, 1'b1};
   assign active     = run && !clr;
   assign phase_nx   = (phase == phase_last) ? '0 : phase + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         mdc   <= 1'b0;
      end else if (!active) begin
         phase <= '0;
         mdc   <= 1'b0;
      end else begin
         phase <= phase_nx;
         mdc   <= (phase_nx > CNT_W'(half_n));
      end
   end

   assign out_stb  = active && (phase == CNT_W'(out_off));
   assign in_stb   = active && (phase == CNT_W'(in_off));
   assign wrap_stb = active && (phase == phase_last);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq import mdio_gw_pkg::*; #(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        clr,
   input  logic        out_stb,
   input  logic        in_stb,
   input  logic        wrap_stb,
   input  logic        st_bit,
   input  logic [1:0]  opcode,
   input  logic [4:0]  phy_ad,
   input  logic [4:0]  reg_ad,
   input  logic [15:0] wr_data,
   input  logic        mdio_in,
   output logic        mdio_out,
   output logic        mdio_oe,
   output logic        done,
   output logic [15:0] rd_data
);
   localparam int FRAME_LEN = PRE_LEN + 32;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam int TA_POS    = PRE_LEN + 14;
   localparam int DATA_POS  = PRE_LEN + 16;
   localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_LEN - 1);

   logic [FRAME_LEN-1:0] frame;
   logic [IDX_W-1:0]     bit_pos, sel;
   logic [15:0]          cap_sr;
   logic                 is_rd, at_end;

   assign frame  = {{PRE_LEN{1'b1}}, 1'b0, st_bit, opcode, phy_ad, reg_ad, 2'b10, wr_data};
   assign is_rd  = (opcode == OP_READ);
   assign sel    = LAST_POS - bit_pos;
   assign at_end = (bit_pos == LAST_POS);
   assign done   = wrap_stb && at_end;
   assign rd_data = cap_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_pos  <= '0;
         mdio_out <= 1'b0;
         mdio_oe  <= 1'b0;
         cap_sr   <= '0;
      end else if (!run || clr) begin
         bit_pos  <= '0;
         mdio_out <= 1'b0;
         mdio_oe  <= 1'b0;
      end else begin
         if (out_stb) begin
            mdio_out <= frame[sel];
            mdio_oe  <= !(is_rd && (bit_pos >= IDX_W'(TA_POS)));
         end
         if (in_stb && is_rd && (bit_pos >= IDX_W'(DATA_POS)))
            cap_sr <= {cap_sr[14:0], mdio_in};
         if (wrap_stb) begin
            if (at_end) begin
               mdio_out <= 1'b0;
               mdio_oe  <= 1'b0;
            end else begin
               bit_pos <= bit_pos + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mdio_pad.sv
module mdio_pad #(
   parameter bit OPEN_DRAIN = 1'b0
) (
   inout  wire  pin,
   input  logic dout,
   input  logic doe,
   output logic din
);
   generate
      if (OPEN_DRAIN) begin : g_od
         assign pin = (doe && !dout) ? 1'b0 : 1'bz;
      end else begin : g_pp
         assign pin = doe ? dout : 1'bz;
      end
   endgenerate

   assign din = pin;

endmodule

// File: rtl/mdio_gw_master.sv
module mdio_gw_master import mdio_gw_pkg::*; #(
   parameter int          ADDR_W     = 4,
   parameter int          PRE_LEN    = 32,
   parameter bit          OPEN_DRAIN = 1'b0,
   parameter logic [31:0] CFG_RST    = 32'h0D06_5515
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mdc,
   inout  wire               mdio,
   output logic              mdio_drive_en,
   output logic [1:0]        pad_mode,
   output logic              pad_3v3,
   output logic              pad_full_drive
);
   localparam int WIDX_W = ADDR_W - 2;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3 to decode two words");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be positive");
   end

   logic [31:0] gw_q;
   mdio_cfg_t   cfg_q;
   logic        gw_sel, cfg_sel, busy, abort, gw_wr_nz, is_rd;
   logic        out_stb, in_stb, wrap_stb, done;
   logic        mdo, mdi;
   logic [15:0] cap_data;

   assign gw_sel   = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:2] == WIDX_W'(0));
   assign cfg_sel  = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:2] == WIDX_W'(1));
   assign busy     = gw_q[GW_BUSY];
   assign abort    = bus_wr && gw_sel && (bus_wdata == 32'h0);
   assign gw_wr_nz = bus_wr && gw_sel && (bus_wdata != 32'h0);
   assign is_rd    = (gw_q[GW_OP_LSB +: 2] == OP_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gw_q <= '0;
      end else if (abort) begin
         gw_q <= '0;
      end else if (done) begin
         gw_q[GW_BUSY] <= 1'b0;
         if (is_rd) gw_q[15:0] <= cap_data;
      end else if (gw_wr_nz && !busy) begin
         gw_q <= bus_wdata & GW_KEEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cfg_q <= mdio_cfg_t'(CFG_RST);
      else if (bus_wr && cfg_sel) cfg_q <= mdio_cfg_t'(bus_wdata);
   end

   always_comb begin
      bus_rdata = 32'h0;
      if (gw_sel)       bus_rdata = gw_q;
      else if (cfg_sel) bus_rdata = cfg_q;
   end

   assign pad_mode       = cfg_q.mode;
   assign pad_3v3        = cfg_q.sel_3v3;
   assign pad_full_drive = cfg_q.full_drv;

   mdio_mdc_gen #(.FLD_W(FLD_W)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .clr      (abort),
      .half_n   (cfg_q.half_n),
      .in_off   (cfg_q.in_off),
      .out_off  (cfg_q.out_off),
      .mdc      (mdc),
      .out_stb  (out_stb),
      .in_stb   (in_stb),
      .wrap_stb (wrap_stb)
   );

   mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .clr      (abort),
      .out_stb  (out_stb),
      .in_stb   (in_stb),
      .wrap_stb (wrap_stb),
      .st_bit   (gw_q[GW_ST]),
      .opcode   (gw_q[GW_OP_LSB +: 2]),
      .phy_ad   (gw_q[GW_PHY_LSB +: 5]),
      .reg_ad   (gw_q[GW_REG_LSB +: 5]),
      .wr_data  (gw_q[15:0]),
      .mdio_in  (mdi),
      .mdio_out (mdo),
      .mdio_oe  (mdio_drive_en),
      .done     (done),
      .rd_data  (cap_data)
   );

   mdio_pad #(.OPEN_DRAIN(OPEN_DRAIN)) u_pad (
      .pin  (mdio),
      .dout (mdo),
      .doe  (mdio_drive_en),
      .din  (mdi)
   );

endmodule

// File: rtl/mdio_gw_checks.sv
module mdio_gw_checks (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        mdc,
   input logic        oe,
   input logic        out_stb,
   input logic        done,
   input logic        abort,
   input logic        gw_wr_nz,
   input logic [12:0] gw_fields
);

   // R12: idle pins quiet
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !oe));

   // R2: busy only falls through completion or abort
   p_busy_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !abort) |=> busy);

   // R7: enable moves only after the output phase strobe
   p_out_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$stable(oe)) |-> $past(out_stb));

   // R9: command fields untouched by a write while busy
   p_busy_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && gw_wr_nz) |=> $stable(gw_fields));

   // R10: abort takes effect on the next cycle
   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !mdc && !oe));

endmodule

bind mdio_gw_master mdio_gw_checks u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .mdc       (mdc),
   .oe        (mdio_drive_en),
   .out_stb   (out_stb),
   .done      (done),
   .abort     (abort),
   .gw_wr_nz  (gw_wr_nz),
   .gw_fields (gw_q[28:16])
);

// File: tb/tb_mdio_gw_master.sv
module tb_mdio_gw_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        mdc, oe;
   logic [1:0]  pad_mode;
   logic        pad_3v3, pad_full_drive;
   wire         mdio_w;

   logic        phy_oe = 1'b0;
   logic        phy_do = 1'b0;
   assign mdio_w = phy_oe ? phy_do : 1'bz;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   int abort_cnt = 0;

   always #2 clk = ~clk;

   mdio_gw_master dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio(mdio_w),
      .mdio_drive_en(oe), .pad_mode(pad_mode), .pad_3v3(pad_3v3),
      .pad_full_drive(pad_full_drive)
   );

   function automatic logic [15:0] init_val(input int i);
      return 16'hA5C3 ^ 16'(i * 16'h1111);
   endfunction

   // PHY behavioural model
   logic [15:0] phy_mem [32];
   bit          ph_inited = 0;
   int          abort_seen = 0;
   int          ph_state = 0, ph_ones = 0, ph_pos = 0, ph_frames = 0;
   logic [63:0] ph_fr = '0;
   logic [15:0] ph_rdv = '0;
   logic [1:0]  ph_op = '0, ph_ta = '0;
   logic [4:0]  ph_phy = '0, ph_reg = '0;
   logic        ph_st = 1'b0;
   logic [15:0] ph_data = '0;

   always @(posedge mdc) begin
      logic b;
      if (!ph_inited) begin
         for (int i = 0; i < 32; i++) phy_mem[i] = init_val(i);
         ph_inited = 1;
      end
      if (abort_seen != abort_cnt) begin
         abort_seen = abort_cnt;
         ph_state = 0; ph_ones = 0; phy_oe = 1'b0;
      end
      b = (mdio_w === 1'b1);
      if (ph_state == 0) begin
         if (b) ph_ones++;
         else begin
            if (ph_ones >= 32) begin ph_state = 1; ph_pos = 32; ph_fr = '0; end
            ph_ones = 0;
         end
      end else begin
         ph_pos++;
         ph_fr[63-ph_pos] = b;
         if (ph_pos == 45) ph_rdv = phy_mem[ph_fr[22:18]];
         if (ph_fr[29:28] == 2'b10 && ph_pos >= 46 && ph_pos <= 62) begin
            phy_oe = 1'b1;
            phy_do = (ph_pos == 46) ? 1'b0 : ph_rdv[62-ph_pos];
         end
         if (ph_pos == 63) begin
            phy_oe = 1'b0;
            ph_st = ph_fr[30]; ph_op = ph_fr[29:28]; ph_phy = ph_fr[27:23];
            ph_reg = ph_fr[22:18]; ph_ta = ph_fr[17:16]; ph_data = ph_fr[15:0];
            if (ph_op == 2'b01) phy_mem[ph_reg] = ph_data;
            ph_frames++;
            ph_state = 0; ph_ones = 0;
         end
      end
   end

   logic [15:0] exp_mem [32];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'h0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] ph,
                                          input logic [4:0] rg, input logic [15:0] dt);
      return {1'b0, 1'b1, 1'b0, 1'b1, op, ph, rg, dt};
   endfunction

   task automatic run_frame(input logic [1:0] op, input logic [4:0] ph, input logic [4:0] rg,
                            input logic [15:0] dt, input int n, input int oo, input int io,
                            input logic [31:0] intr);
      logic [31:0] cmd, rd;
      int c, fhi, ffall, foe, oe_bad, per, f0;
      per = 2 * (n + 1);
      bus_write(4'h4, {8'(oo), 8'(io), 8'(n), 8'h15});
      cmd = mk_cmd(op, ph, rg, dt);
      f0 = ph_frames;
      bus_write(4'h0, cmd);
      c = 0; fhi = -1; ffall = -1; foe = -1; oe_bad = 0;
      forever begin
         #1;
         if (bus_rdata[30] !== 1'b1) break;
         if (mdc && fhi < 0) fhi = c;
         if (!mdc && fhi >= 0 && ffall < 0) ffall = c;
         if (oe && foe < 0) foe = c;
         if (op == 2'b01 && foe >= 0 && !oe) oe_bad++;
         if (op == 2'b10 && c >= 46 * per + oo + 1 && oe) oe_bad++;
         if (c == 52 && intr != 0) chk("R9 fields kept while busy", {19'h0, bus_rdata[28:16]}, {19'h0, cmd[28:16]});
         c++;
         @(negedge clk);
         if (c == 50 && intr != 0) begin bus_wr = 1'b1; bus_wdata = intr; end
         else begin bus_wr = 1'b0; bus_wdata = 32'h0; end
         if (c > 150000) break;
      end
      chk("R2 busy duration", 32'(c), 32'(128 * (n + 1)));
      chk("R3 first MDC rise", 32'(fhi), 32'(n + 1));
      chk("R3 first MDC fall", 32'(ffall), 32'(2 * (n + 1)));
      chk("R7 first enable offset", 32'(foe), 32'(oo + 1));
      chk(op == 2'b01 ? "R5 enable held" : "R6 enable released", 32'(oe_bad), 32'h0);
      chk("R12 idle after frame", {30'h0, mdc, oe}, 32'h0);
      chk("R4 PHY saw one frame", 32'(ph_frames), 32'(f0 + 1));
      chk("R4 start/op/phy/reg", {ph_st, ph_op, ph_phy, ph_reg}, {1'b1, op, ph, rg});
      bus_read(4'h0, rd);
      if (op == 2'b01) begin
         chk("R5 write data on wire", {16'h0, ph_data}, {16'h0, dt});
         chk("R5 turnaround 10", {30'h0, ph_ta}, 32'h2);
         chk("R5 gateway after write", rd, cmd & 32'h1FFF_FFFF);
         exp_mem[rg] = dt;
      end else begin
         chk("R6 R8 gateway read result", rd, (cmd & 32'h1FFF_0000) | {16'h0, exp_mem[rg]});
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd, r;
      int seed_use;
      seed_use = $urandom(1234);
      for (int i = 0; i < 32; i++) exp_mem[i] = init_val(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(4'h0, rd); chk("R1 gateway reset", rd, 32'h0);
      bus_read(4'h4, rd); chk("R1 config reset", rd, 32'h0D06_5515);
      chk("R1 pins reset", {27'h0, mdc, oe, pad_mode, pad_3v3 & pad_full_drive}, {27'h0, 1'b0, 1'b0, 2'b01, 1'b1});

      // R11 config readback and pad outputs
      r = $urandom;
      bus_write(4'h4, r);
      bus_read(4'h4, rd); chk("R11 config readback", rd, r);
      chk("R11 pad outputs", {28'h0, pad_mode, pad_3v3, pad_full_drive}, {28'h0, r[1:0], r[2], r[4]});
      bus_write(4'h4, 32'h0D06_5515);

      // R13 store without launch
      bus_write(4'h0, 32'hA000_0001);
      bus_read(4'h0, rd); chk("R13 masked bits", rd, 32'h0000_0001);
      bus_write(4'h0, 32'h0ABC_1234);
      begin
         int f0, hi;
         f0 = ph_frames; hi = 0;
         for (int k = 0; k < 40; k++) begin @(negedge clk); #1 if (mdc || oe) hi++; end
         chk("R13 no frame started", 32'(hi), 32'h0);
         chk("R13 PHY idle", 32'(ph_frames), 32'(f0));
      end
      bus_read(4'h0, rd); chk("R13 stored word", rd, 32'h0ABC_1234);

      // default configuration frame: N=85, out 13, in 6
      run_frame(2'b10, 5'd3, 5'd7, 16'h0, 85, 13, 6, 32'h0);

      // directed write then read-back of same register
      run_frame(2'b01, 5'd31, 5'd0, 16'hFFFF, 2, 0, 0, 32'h0);
      run_frame(2'b10, 5'd31, 5'd0, 16'h0, 2, 1, 2, 32'h0);

      // R9 intruding write while busy
      run_frame(2'b01, 5'd9, 5'd12, 16'h8001, 3, 2, 1, 32'h4C21_BEEF);

      // random transactions
      for (int t = 0; t < 12; t++) begin
         int n, oo, io;
         logic [1:0] op;
         n  = 2 + int'($urandom % 7);
         oo = int'($urandom % n);
         io = int'($urandom % (n + 1));
         op = ($urandom % 2) ? 2'b01 : 2'b10;
         run_frame(op, 5'($urandom), 5'($urandom), 16'($urandom), n, oo, io, 32'h0);
      end

      // R10 abort mid-frame
      bus_write(4'h4, {8'd1, 8'd2, 8'd5, 8'h15});
      bus_write(4'h0, mk_cmd(2'b10, 5'd4, 5'd5, 16'h0));
      repeat (300) @(negedge clk);
      bus_write(4'h0, 32'h0);
      #1 chk("R10 pins after abort", {30'h0, mdc, oe}, 32'h0);
      bus_read(4'h0, rd); chk("R10 gateway cleared", rd, 32'h0);
      abort_cnt++;
      begin
         int hi;
         hi = 0;
         for (int k = 0; k < 30; k++) begin @(negedge clk); #1 if (mdc || oe) hi++; end
         chk("R10 R12 quiet after abort", 32'(hi), 32'h0);
      end
      run_frame(2'b10, 5'd4, 5'd5, 16'h0, 5, 1, 4, 32'h0);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule